// File: doc/BRIEF.md
# Configurable Bi-Quinary Decade Counter

This block is a four-bit decade counter made from two stages, each advanced by its own count input. A one-bit stage toggles the low output bit. A modulo-five stage steps a three-bit binary value on the upper three output bits. A stage advances when its count input goes from high to low. Both count inputs are sampled on one system clock, and the falling edges are found by comparing successive samples.

A two-bit mode input sets how the stages are wired to each other. In split mode each stage follows only its own input. In BCD mode a high-to-low step of the low bit advances the upper stage, so the four bits count 0 to 9. In bi-quinary mode a wrap of the upper stage advances the low bit. The low bit is then a divide-by-ten output with a 50% duty cycle. A chained carry reaches the next stage in the same system clock, so it is never lost or counted twice.

An active-high reset clears all four outputs at once, without waiting for a clock edge. While reset is high the count inputs have no effect.

Top module: `biquinary_decade`

## Requirements
- R1: In split mode (`mode_i` = 00 or 11), each high-to-low step of `tick_a_i` inverts `q_o[0]`. A low-to-high step of `tick_a_i` leaves `q_o` unchanged.
- R2: The modulo-five stage steps `q_o[3:1]` through the binary values 0,1,2,3,4 and then back to 0. In split mode it advances once for each high-to-low step of `tick_b_i`.
- R3: In BCD mode (`mode_i` = 01), each high-to-low step of `tick_a_i` advances `q_o` as a binary value through 0..9, then back to 0. `q_o[3:1]` steps exactly when `q_o[0]` goes from 1 to 0.
- R4: In bi-quinary mode (`mode_i` = 10), each high-to-low step of `tick_b_i` advances `q_o[3:1]`. `q_o[0]` inverts exactly when `q_o[3:1]` wraps from 4 to 0, so `q_o[0]` is high for five input steps and low for five.
- R5: In BCD mode `tick_b_i` has no effect. In bi-quinary mode `tick_a_i` has no effect.
- R6: In split mode, falling steps on both inputs at the same time advance both stages.
- R7: While `rst` is high, `q_o` is 0. Raising `rst` clears `q_o` before the next clock edge.
- R8: Count-input steps made while `rst` is high are not counted. After `rst` falls, an input held high or held low produces no count; only a later high-to-low step counts.
- R9: Changing `mode_i` leaves `q_o` unchanged.
- R10: Each stage advances at most one step per system clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high reset, clears the count at once |
| mode_i | input | 2 | 00/11 split, 01 BCD, 10 bi-quinary |
| tick_a_i | input | 1 | Count input of the one-bit stage |
| tick_b_i | input | 1 | Count input of the modulo-five stage |
| q_o | output | 4 | Count: bit 0 from the one-bit stage, bits 3:1 from the modulo-five stage |

## Verification
The bench sweeps each mode through more than two full decades and compares every step with an arithmetic model. A carry that arrived one step late, or landed twice, would shift the BCD sequence or break the five-high/five-low pattern of bit 0 in bi-quinary mode. In each chained mode the bench pulses the unused input, to catch wiring that ignores the mode. It checks the count while a count input is high, so a design that counted rising steps would show up. It also tests reset: it clears the count between clock edges, drops inputs while reset is high, and releases reset with an input held high. These steps catch a synchronous clear, edges seen through reset, and a false edge made by stale samples after release.

// File: rtl/bqd_pkg.sv
package bqd_pkg;
  typedef enum logic [1:0] {
    CHAIN_SPLIT = 2'b00,
    CHAIN_BCD   = 2'b01,
    CHAIN_BIQ   = 2'b10,
    CHAIN_ALT   = 2'b11
  } chain_e;
endpackage

// File: rtl/bqd_fall_detect.sv
module bqd_fall_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic fell
);
  logic sampled;
  logic prev_q;

  generate
    if (SYNC_STAGES == 0) begin : g_direct
      assign sampled = din;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk or posedge rst) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2 >= 0 ? SYNC_STAGES-2 : 0:0], din} & {SYNC_STAGES{1'b1}};
      end
      assign sampled = sync_q[SYNC_STAGES-1];
    end
  endgenerate

  // prev cleared to 0 in reset: a falling edge needs prev==1, so none can be
  // reported in the first clock after release.
  always_ff @(posedge clk or posedge rst) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sampled;
  end

  assign fell = prev_q & ~sampled;

  // R8: no edge reported on the first clock after reset is released
  a_r8_quiet_after_release: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !fell);
endmodule

// File: rtl/bqd_div2.sv
module bqd_div2 (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  output logic q,
  output logic falls
);
  always_ff @(posedge clk or posedge rst) begin
    if (rst)      q <= 1'b0;
    else if (adv) q <= ~q;
  end

  assign falls = adv & q;
endmodule

// File: rtl/bqd_div5.sv
module bqd_div5 #(
  parameter int MODULUS = 5,
  localparam int CW = $clog2(MODULUS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  output logic [CW-1:0] cnt,
  output logic          wraps
);
  localparam logic [CW-1:0] LAST = CW'(MODULUS - 1);

  always_ff @(posedge clk or posedge rst) begin
    if (rst)             cnt <= '0;
    else if (adv) begin
      if (cnt == LAST)   cnt <= '0;
      else               cnt <= cnt + 1'b1;
    end
  end

  assign wraps = adv & (cnt == LAST);

  // R2: count never leaves 0..MODULUS-1
  a_r2_in_range: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
  // R10: at most one step per clock
  a_r10_single_step: assert property (@(posedge clk) disable iff (rst)
    (cnt != $past(cnt)) |->
      ((cnt == $past(cnt) + 1'b1) || (cnt == '0 && $past(cnt) == LAST)));
endmodule

// File: rtl/biquinary_decade.sv
module biquinary_decade #(
  parameter int SYNC_STAGES = 2,
  parameter int HI_MODULUS  = 5,
  localparam int HW = $clog2(HI_MODULUS)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  mode_i,
  input  logic        tick_a_i,
  input  logic        tick_b_i,
  output logic [HW:0] q_o
);
  import bqd_pkg::*;

  logic          edge_a, edge_b;
  logic          adv_lo, adv_hi;
  logic          lo_q, lo_falls;
  logic [HW-1:0] hi_q;
  logic          hi_wraps;

  bqd_fall_detect #(.SYNC_STAGES(SYNC_STAGES)) u_det_a (
    .clk(clk), .rst(rst), .din(tick_a_i), .fell(edge_a));
  bqd_fall_detect #(.SYNC_STAGES(SYNC_STAGES)) u_det_b (
    .clk(clk), .rst(rst), .din(tick_b_i), .fell(edge_b));

  always_comb begin
    case (chain_e'(mode_i))
      CHAIN_BCD: begin
        adv_lo = edge_a;
        adv_hi = lo_falls;
      end
      CHAIN_BIQ: begin
        adv_hi = edge_b;
        adv_lo = hi_wraps;
      end
      default: begin
        adv_lo = edge_a;
        adv_hi = edge_b;
      end
    endcase
  end

  bqd_div2 u_lo (
    .clk(clk), .rst(rst), .adv(adv_lo), .q(lo_q), .falls(lo_falls));
  bqd_div5 #(.MODULUS(HI_MODULUS)) u_hi (
    .clk(clk), .rst(rst), .adv(adv_hi), .cnt(hi_q), .wraps(hi_wraps));

  assign q_o = {hi_q, lo_q};

  // R7: output is clear at every clock while reset is high
  a_r7_reset_clears: assert property (@(posedge clk)
    rst |-> (q_o == '0));
  // R3: in BCD mode the upper stage moves only as bit 0 falls
  a_r3_bcd_carry: assert property (@(posedge clk) disable iff (rst)
    ($past(mode_i) == 2'b01 && hi_q != $past(hi_q)) |-> ($past(lo_q) && !lo_q));
  // R4: in bi-quinary mode bit 0 moves only on the 4 -> 0 wrap
  a_r4_biq_carry: assert property (@(posedge clk) disable iff (rst)
    ($past(mode_i) == 2'b10 && lo_q != $past(lo_q)) |->
      ($past(hi_q) == HW'(HI_MODULUS - 1) && hi_q == '0));
endmodule

// File: tb/biquinary_decade_tb.sv
module biquinary_decade_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode = 2'b00;
  logic       ta = 1'b0;
  logic       tb = 1'b0;
  logic [3:0] q;

  int n_vec = 0;
  int n_bad = 0;
  int m_lo = 0;
  int m_hi = 0;

  always #5 clk = ~clk;

  biquinary_decade dut_i (
    .clk(clk), .rst(rst), .mode_i(mode),
    .tick_a_i(ta), .tick_b_i(tb), .q_o(q));

  function automatic logic [3:0] expv();
    return {m_hi[2:0], m_lo[0]};
  endfunction

  task automatic chk(input string req, input logic [3:0] exp);
    n_vec++;
    if (q !== exp) begin
      n_bad++;
      $display("FAIL %s: q=%0d expected %0d", req, q, exp);
    end
  endtask

  task automatic model(input bit ea, input bit eb);
    bit al, ah;
    if (mode == 2'b01)      begin al = ea; ah = ea && (m_lo == 1); end
    else if (mode == 2'b10) begin ah = eb; al = eb && (m_hi == 4); end
    else                    begin al = ea; ah = eb; end
    if (ah) m_hi = (m_hi == 4) ? 0 : m_hi + 1;
    if (al) m_lo = 1 - m_lo;
  endtask

  // high phase then falling step; checks rise had no effect, then the fall
  task automatic pulse(input bit a, input bit b, input string req);
    @(negedge clk);
    ta = a; tb = b;
    repeat (4) @(negedge clk);
    if (!rst) chk("R1 rise ignored", expv());
    ta = 1'b0; tb = 1'b0;
    repeat (5) @(negedge clk);
    if (!rst) model(a, b);
    chk(req, rst ? 4'd0 : expv());
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    m_lo = 0; m_hi = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R7 reset state", 4'd0);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // split mode
    for (int i = 0; i < 12; i++) pulse(1, 0, "R1 split lo toggle");
    for (int i = 0; i < 12; i++) pulse(0, 1, "R2 split hi mod5");
    for (int i = 0; i < 7; i++)  pulse(1, 1, "R6 simultaneous");
    mode = 2'b11;
    for (int i = 0; i < 4; i++)  pulse(1, 1, "R6 mode 11 split");

    // BCD
    do_reset();
    mode = 2'b01;
    for (int i = 0; i < 25; i++) pulse(1, 0, "R3 bcd count");
    for (int i = 0; i < 4; i++)  pulse(0, 1, "R5 tick_b ignored in bcd");

    // mode change keeps count
    mode = 2'b10;
    repeat (5) @(negedge clk);
    chk("R9 mode change to biq", expv());
    mode = 2'b00;
    repeat (5) @(negedge clk);
    chk("R9 mode change to split", expv());

    // bi-quinary
    do_reset();
    mode = 2'b10;
    for (int i = 0; i < 25; i++) pulse(0, 1, "R4 biq count");
    for (int i = 0; i < 4; i++)  pulse(1, 0, "R5 tick_a ignored in biq");

    // asynchronous clear between edges
    @(negedge clk);
    #2 rst = 1'b1;
    #1 chk("R7 async clear", 4'd0);
    m_lo = 0; m_hi = 0;
    mode = 2'b00;
    pulse(1, 1, "R8 edges in reset ignored");
    pulse(1, 0, "R8 edges in reset ignored");
    // input held high across release
    @(negedge clk);
    ta = 1'b1; tb = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (6) @(negedge clk);
    chk("R8 no false edge on release", 4'd0);
    ta = 1'b0;
    repeat (5) @(negedge clk);
    model(1, 0);
    chk("R8 first real edge after release", expv());
    // input dropped while in reset, then released low
    @(negedge clk);
    rst = 1'b1;
    m_lo = 0; m_hi = 0;
    repeat (2) @(negedge clk);
    tb = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (6) @(negedge clk);
    chk("R8 drop during reset not counted", 4'd0);
    pulse(0, 1, "R2 counts after reset");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: q=%0d expected completion", q);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule